// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data addresses for indirect memory access. It holds a file of buffer descriptors. Each descriptor has four registers: pointer, modifier, length and base. There are two complete sets of descriptors, primary and secondary, so the block can track twice as many buffers as one set holds. When a request names a descriptor, the block issues that descriptor's pointer as the access address. It then advances the pointer by the modifier and folds it back inside the buffer when it runs past either end.

A buffer may begin at any address and have any length; no power-of-two alignment is needed. The modifier is a two's complement value, so buffers can be walked upward or downward. A zero length turns the fold off and makes that descriptor a plain linear pointer. A write port loads the descriptors, and a set-select input chooses which of the two sets all requests and writes act on.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, `addr_vld` and `addr_out` are 0, every register of both sets is 0 and the primary set is active.
- R2: A request sampled at a clock edge makes `addr_vld` 1 and `addr_out` the addressed pointer's value before the update, both visible after that edge. Without a request, `addr_vld` is 0 on the following cycle and `addr_out` holds its last value.
- R3: After each request the addressed pointer becomes pointer plus modifier, with the modifier read as a signed two's complement value.
- R4: When length is non-zero and pointer plus modifier is at or above base plus length, length is subtracted from the result.
- R5: When length is non-zero and pointer plus modifier is below base, length is added to the result. Any modifier whose magnitude is at most the length keeps an in-range pointer inside the buffer.
- R6: A length of 0 makes the update linear with no fold, wrapping only modulo 2^32.
- R7: `wr_kind` selects the register written: 0 pointer, 1 modifier, 2 length, 3 base. A base write also loads the pointer with the same value.
- R8: `bank_sel` (0 primary, 1 secondary) is registered. A change affects requests and writes from the next clock edge on, and the two sets are independent.
- R9: When a pointer or base write and a request hit the same descriptor in one cycle, the written value replaces the post-modify result, and the issued address is still the old pointer.
- R10: Base and length need no alignment; an odd base and an odd length fold correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | Set select, 0 primary, 1 secondary |
| req_valid | input | 1 | Access request |
| req_idx | input | 4 | Descriptor index of the request |
| wr_en | input | 1 | Register write enable |
| wr_kind | input | 2 | Register written: 0 pointer, 1 modifier, 2 length, 3 base |
| wr_idx | input | 4 | Descriptor index of the write |
| wr_data | input | 32 | Write data |
| addr_vld | output | 1 | Address valid, one cycle after a request |
| addr_out | output | 32 | Issued address |

## Verification
Each issued address appears one clock edge after its request is sampled. The pointer update and any register write take effect at that same edge, so the next request may already use the new values. A change of `bank_sel` counts one edge before it steers anything. The bench drives inputs on the falling edge and samples `addr_out` on the next falling edge, half a cycle after the edge that produced it. A request issued in the same cycle as a set change is checked against the old set, and a write that collides with a request is checked with a later access.

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int AW    = 32,
  parameter int NSETS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bank_sel,
  input  logic                      req_valid,
  input  logic [$clog2(NSETS)-1:0]  req_idx,
  input  logic                      wr_en,
  input  logic [1:0]                wr_kind,
  input  logic [$clog2(NSETS)-1:0]  wr_idx,
  input  logic [AW-1:0]             wr_data,
  output logic                      addr_vld,
  output logic [AW-1:0]             addr_out
);
  localparam int IW   = $clog2(NSETS);
  localparam int NREG = 2 * NSETS;
  localparam int SW   = IW + 1;

  logic          bank_q;
  logic [AW-1:0] ptr_r  [NREG];
  logic [AW-1:0] mod_r  [NREG];
  logic [AW-1:0] len_r  [NREG];
  logic [AW-1:0] base_r [NREG];

  logic [SW-1:0] rsel, wsel;
  assign rsel = {bank_q, req_idx};
  assign wsel = {bank_q, wr_idx};

  logic [AW-1:0] cur_ptr, cur_mod, cur_len, cur_base, nxt_ptr;
  assign cur_ptr  = ptr_r[rsel];
  assign cur_mod  = mod_r[rsel];
  assign cur_len  = len_r[rsel];
  assign cur_base = base_r[rsel];

  logic signed [AW+1:0] sum, lo_v, hi_v, len_v, folded;
  assign sum   = $signed({2'b00, cur_ptr}) + $signed({{2{cur_mod[AW-1]}}, cur_mod});
  assign lo_v  = $signed({2'b00, cur_base});
  assign len_v = $signed({2'b00, cur_len});
  assign hi_v  = lo_v + len_v;

  always_comb begin
    folded = sum;
    if (cur_len != '0) begin
      if (sum >= hi_v)      folded = sum - len_v;
      else if (sum < lo_v)  folded = sum + len_v;
    end
  end

  assign nxt_ptr = folded[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q   <= 1'b0;
      addr_vld <= 1'b0;
      addr_out <= '0;
      for (int i = 0; i < NREG; i++) begin
        ptr_r[i]  <= '0;
        mod_r[i]  <= '0;
        len_r[i]  <= '0;
        base_r[i] <= '0;
      end
    end else begin
      bank_q   <= bank_sel;
      addr_vld <= req_valid;
      if (req_valid) begin
        addr_out    <= cur_ptr;
        ptr_r[rsel] <= nxt_ptr;
      end
      if (wr_en) begin
        case (wr_kind)
          2'd0: ptr_r[wsel] <= wr_data;
          2'd1: mod_r[wsel] <= wr_data;
          2'd2: len_r[wsel] <= wr_data;
          default: begin
            base_r[wsel] <= wr_data;
            ptr_r[wsel]  <= wr_data;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          addr_vld,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] cur_ptr,
  input logic [AW-1:0] cur_mod,
  input logic [AW-1:0] cur_len,
  input logic [AW-1:0] cur_base,
  input logic [AW-1:0] nxt_ptr
);
  logic [AW+1:0] b2, l2, p2, n2;
  logic [AW-1:0] mag;
  logic          in_rng, small_step, fits;
  assign b2 = {2'b00, cur_base};
  assign l2 = {2'b00, cur_len};
  assign p2 = {2'b00, cur_ptr};
  assign n2 = {2'b00, nxt_ptr};
  assign mag = cur_mod[AW-1] ? (~cur_mod + 1'b1) : cur_mod;
  assign fits = (b2 + l2) <= ({2'b01, {AW{1'b0}}});
  assign in_rng = (p2 >= b2) && (p2 < b2 + l2);
  assign small_step = mag <= cur_len;

  assert_vld_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_vld);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_vld && $stable(addr_out)));

  assert_issue_old_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (addr_out == $past(cur_ptr)));

  // R4, R5: a legal step from inside the buffer stays inside it
  assert_fold_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_len != '0 && fits && in_rng && small_step) |-> (n2 >= b2 && n2 < b2 + l2));

  assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_len == '0) |-> (nxt_ptr == cur_ptr + cur_mod));
endmodule

bind circ_addr_gen circ_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr_vld(addr_vld),
  .addr_out(addr_out), .cur_ptr(cur_ptr), .cur_mod(cur_mod), .cur_len(cur_len),
  .cur_base(cur_base), .nxt_ptr(nxt_ptr)
);

// File: tb/tb_circ_addr_gen.sv
module tb_circ_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_sel = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_idx = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        addr_vld;
  logic [31:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  circ_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .req_valid(req_valid),
    .req_idx(req_idx), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .addr_vld(addr_vld), .addr_out(addr_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] kind, input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic access(input string req, input logic [3:0] idx, input logic [31:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_idx = idx;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {31'd0, addr_vld}, 32'd1);
    check(req, addr_out, exp);
  endtask

  task automatic t_reset;
    check("R1 vld", {31'd0, addr_vld}, 32'd0);
    check("R1 addr", addr_out, 32'd0);
    access("R1 reg zero", 4'd5, 32'd0);
    access("R1 reg zero again", 4'd5, 32'd0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    check("R2 idle vld", {31'd0, addr_vld}, 32'd0);
    check("R2 idle hold", addr_out, 32'd0);
  endtask

  task automatic t_linear;
    wreg(2'd0, 4'd1, 32'd100);
    wreg(2'd1, 4'd1, 32'd4);
    access("R3 linear", 4'd1, 32'd100);
    access("R3 linear", 4'd1, 32'd104);
    access("R3 linear", 4'd1, 32'd108);
    wreg(2'd0, 4'd6, 32'hFFFF_FFFE);
    wreg(2'd1, 4'd6, 32'd4);
    access("R6 top", 4'd6, 32'hFFFF_FFFE);
    access("R6 modulo wrap", 4'd6, 32'd2);
    wreg(2'd1, 4'd6, 32'hFFFF_FFFD);
    access("R3 negative", 4'd6, 32'd6);
    access("R3 negative", 4'd6, 32'd3);
  endtask

  task automatic t_wrap_up;
    wreg(2'd2, 4'd2, 32'd10);
    wreg(2'd1, 4'd2, 32'd3);
    wreg(2'd3, 4'd2, 32'd1003);
    access("R7 base loads ptr", 4'd2, 32'd1003);
    access("R10 odd base", 4'd2, 32'd1006);
    access("R10 odd base", 4'd2, 32'd1009);
    access("R4 below end", 4'd2, 32'd1012);
    access("R4 wrap up", 4'd2, 32'd1005);
    wreg(2'd1, 4'd2, 32'd10);
    access("R4 step len", 4'd2, 32'd1008);
    access("R4 step len", 4'd2, 32'd1008);
  endtask

  task automatic t_wrap_down;
    wreg(2'd2, 4'd3, 32'd7);
    wreg(2'd3, 4'd3, 32'd500);
    wreg(2'd1, 4'd3, -32'sd7);
    access("R5 step -len", 4'd3, 32'd500);
    access("R5 step -len", 4'd3, 32'd500);
    wreg(2'd1, 4'd3, -32'sd3);
    access("R5 down", 4'd3, 32'd500);
    access("R5 wrap down", 4'd3, 32'd504);
    access("R5 down", 4'd3, 32'd501);
    access("R5 wrap down", 4'd3, 32'd505);
  endtask

  task automatic t_bank;
    wreg(2'd0, 4'd8, 32'd111);
    @(negedge clk);
    bank_sel = 1'b1; req_valid = 1'b1; req_idx = 4'd8;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 old set same cycle", addr_out, 32'd111);
    access("R8 secondary zero", 4'd8, 32'd0);
    wreg(2'd0, 4'd8, 32'd222);
    access("R8 secondary", 4'd8, 32'd222);
    @(negedge clk);
    bank_sel = 1'b0;
    @(negedge clk);
    access("R8 primary kept", 4'd8, 32'd111);
  endtask

  task automatic t_collide;
    wreg(2'd0, 4'd4, 32'd50);
    wreg(2'd1, 4'd4, 32'd1);
    @(negedge clk);
    req_valid = 1'b1; req_idx = 4'd4;
    wr_en = 1'b1; wr_kind = 2'd0; wr_idx = 4'd4; wr_data = 32'd77;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    check("R9 old issued", addr_out, 32'd50);
    access("R9 write wins", 4'd4, 32'd77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_linear();
    t_wrap_up();
    t_wrap_down();
    t_bank();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule